// File: doc/BRIEF.md
# Hybrid Circuit/Packet Output Port Arbiter

This block is the output-port logic of one mesh router link that carries two kinds of traffic at once. Flits that belong to an established circuit arrive on the input chosen by the stored crossbar mapping. They are sent out after a single registered switch-traversal stage, with no routing or allocation. Packet-switched flits wait in the input buffers of the normal pipeline. Each buffered input raises a request toward this output. A round-robin allocator picks one winner per cycle, and the winner traverses the switch in the next cycle.

Circuit traffic always has strict priority. A packet grant that meets a circuit flit in its traversal cycle is cancelled, and the packet flit stays in its buffer and competes again. Packet flits can therefore use any link cycle that the circuit leaves idle. Each flit on the output link carries a one-bit kind tag, so the next router knows whether to send it straight through or to buffer it.

Top module: `hcs_out_arb`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `link_vld` and `link_circ` are 0, `pkt_sent` is all zeros and `pkt_cancel` is 0. The round-robin pointer starts at input 0.
- R2: When `map_en` is 1 and `circ_vld[map_src]` is 1 in a cycle, the next clock edge puts `circ_data` slice `map_src` on `link_data`, with `link_vld`=1 and `link_circ`=1 (kind tag 1 means circuit).
- R3: A circuit flit on an input other than `map_src`, or any circuit flit while `map_en` is 0, is ignored and never reaches the link.
- R4: In the cycle after a packet grant to input i, if no mapped circuit flit is present, `pkt_sent` is one-hot at bit i. At the next edge the link then carries that cycle's `pkt_data` slice i with `link_vld`=1 and `link_circ`=0 (kind tag 0 means packet).
- R5: If a mapped circuit flit is present in a granted packet's traversal cycle, `pkt_cancel` is 1, `pkt_sent` is all zeros and the circuit flit takes the link.
- R6: The allocator searches cyclically for the first requesting input, starting from the input after the last one granted.
- R7: The input whose flit is being sent in a cycle is left out of that cycle's allocation.
- R8: In a cycle with neither a mapped circuit flit nor a packet being sent, the next edge drives `link_vld`=0, `link_circ`=0 and `link_data`=0.
- R9: `pkt_sent` has at most one bit set and is non-zero only in the cycle that follows a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_en | input | 1 | A circuit is configured on this output |
| map_src | input | $clog2(N) | Input index that the circuit maps to this output |
| circ_vld | input | N | Circuit flit valid, one bit per input |
| circ_data | input | N*W | Circuit flit payloads, slice i for input i |
| pkt_req | input | N | Buffered packet flit at head requests this output |
| pkt_data | input | N*W | Head packet flit payloads, slice i for input i |
| pkt_sent | output | N | One-hot: head flit of that input leaves this cycle |
| pkt_cancel | output | 1 | Pending packet grant dropped for circuit priority |
| link_vld | output | 1 | Output link flit valid |
| link_circ | output | 1 | Kind tag: 1 circuit, 0 packet |
| link_data | output | W | Output link flit payload |

## Verification
The bench goes after cycles where a grant is already pending and a mapped circuit flit arrives. A design without strict priority would put the packet on the link or report it sent, and the flit would be lost or duplicated. It drives circuit valids on unmapped inputs and while the mapping is disabled, where a mux without the enable or source qualification would leak foreign flits. It also keeps all inputs requesting back to back, so that a pointer that does not rotate, or an allocator that regrants the input just sent, gives the wrong winner or a repeated `pkt_sent`.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
  typedef enum logic {
    KIND_PKT  = 1'b0,
    KIND_CIRC = 1'b1
  } flit_kind_e;
endpackage

// File: rtl/hcs_rr_arb.sv
module hcs_rr_arb #(
  parameter int N  = 5,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic          pick_vld,
  output logic [IW-1:0] pick_idx
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int k = 0; k < N; k++) begin
      int c;
      c = int'(ptr_q) + k;
      if (c >= N) c = c - N;
      if (!pick_vld && req[c]) begin
        pick_vld = 1'b1;
        pick_idx = IW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (pick_vld) begin
      ptr_q <= (pick_idx == IW'(N - 1)) ? '0 : pick_idx + 1'b1;
    end
  end
endmodule

// File: rtl/hcs_circ_sel.sv
module hcs_circ_sel #(
  parameter int N  = 5,
  parameter int W  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic           map_en,
  input  logic [IW-1:0]  map_src,
  input  logic [N-1:0]   circ_vld,
  input  logic [N*W-1:0] circ_data,
  output logic           hit,
  output logic [W-1:0]   hit_data
);
  logic [W-1:0] lane [N];

  for (genvar g = 0; g < N; g++) begin : g_lane
    assign lane[g] = circ_data[g*W +: W];
  end

  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    if (map_en && int'(map_src) < N) begin
      hit      = circ_vld[map_src];
      hit_data = lane[map_src];
    end
  end
endmodule

// File: rtl/hcs_out_arb.sv
module hcs_out_arb
  import hcs_pkg::*;
#(
  parameter int N  = 5,
  parameter int W  = 32,
  localparam int IW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           map_en,
  input  logic [IW-1:0]  map_src,
  input  logic [N-1:0]   circ_vld,
  input  logic [N*W-1:0] circ_data,
  input  logic [N-1:0]   pkt_req,
  input  logic [N*W-1:0] pkt_data,
  output logic [N-1:0]   pkt_sent,
  output logic           pkt_cancel,
  output logic           link_vld,
  output logic           link_circ,
  output logic [W-1:0]   link_data
);
  logic          hit;
  logic [W-1:0]  hit_data;
  logic          gnt_vld_q;
  logic [IW-1:0] gnt_idx_q;
  logic          sending;
  logic [N-1:0]  arb_req;
  logic          pick_vld;
  logic [IW-1:0] pick_idx;
  logic [W-1:0]  pkt_lane [N];

  for (genvar g = 0; g < N; g++) begin : g_pkt_lane
    assign pkt_lane[g] = pkt_data[g*W +: W];
  end

  hcs_circ_sel #(.N(N), .W(W), .IW(IW)) circ_sel_i (
    .map_en   (map_en),
    .map_src  (map_src),
    .circ_vld (circ_vld),
    .circ_data(circ_data),
    .hit      (hit),
    .hit_data (hit_data)
  );

  // Traversal stage: a pending grant goes out only on a circuit-free cycle.
  assign sending    = gnt_vld_q && !hit;
  assign pkt_cancel = gnt_vld_q && hit;

  always_comb begin
    pkt_sent = '0;
    if (sending) pkt_sent[gnt_idx_q] = 1'b1;
  end

  // Allocation stage: the input leaving this cycle must not be regranted.
  assign arb_req = pkt_req & ~pkt_sent;

  hcs_rr_arb #(.N(N), .IW(IW)) rr_i (
    .clk     (clk),
    .rst     (rst),
    .req     (arb_req),
    .pick_vld(pick_vld),
    .pick_idx(pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_vld_q <= 1'b0;
      gnt_idx_q <= '0;
    end else begin
      gnt_vld_q <= pick_vld;
      gnt_idx_q <= pick_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      link_vld  <= 1'b0;
      link_circ <= KIND_PKT;
      link_data <= '0;
    end else if (hit) begin
      link_vld  <= 1'b1;
      link_circ <= KIND_CIRC;
      link_data <= hit_data;
    end else if (sending) begin
      link_vld  <= 1'b1;
      link_circ <= KIND_PKT;
      link_data <= pkt_lane[gnt_idx_q];
    end else begin
      link_vld  <= 1'b0;
      link_circ <= KIND_PKT;
      link_data <= '0;
    end
  end
endmodule

// File: rtl/hcs_out_arb_chk.sv
module hcs_out_arb_chk #(
  parameter int N  = 5,
  parameter int W  = 32,
  localparam int IW = $clog2(N)
) (
  input logic           clk,
  input logic           rst,
  input logic           map_en,
  input logic [IW-1:0]  map_src,
  input logic [N-1:0]   circ_vld,
  input logic [N*W-1:0] circ_data,
  input logic [N-1:0]   pkt_sent,
  input logic           pkt_cancel,
  input logic           link_vld,
  input logic           link_circ,
  input logic [W-1:0]   link_data
);
  logic         c_hit;
  logic [W-1:0] c_data;

  always_comb begin
    c_hit  = 1'b0;
    c_data = '0;
    if (map_en && int'(map_src) < N) begin
      c_hit  = circ_vld[map_src];
      c_data = circ_data[int'(map_src)*W +: W];
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!link_vld && !link_circ));

  assert_circ_forward_R2: assert property (@(posedge clk) disable iff (rst)
    c_hit |=> (link_vld && link_circ && link_data == $past(c_data)));

  assert_pkt_tag_R4: assert property (@(posedge clk) disable iff (rst)
    (pkt_sent != '0) |=> (link_vld && !link_circ));

  assert_circ_priority_R5: assert property (@(posedge clk) disable iff (rst)
    c_hit |-> (pkt_sent == '0));

  assert_idle_link_R8: assert property (@(posedge clk) disable iff (rst)
    (!c_hit && pkt_sent == '0) |=> (!link_vld && link_data == '0));

  assert_sent_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pkt_sent) && !(pkt_cancel && pkt_sent != '0));
endmodule

bind hcs_out_arb hcs_out_arb_chk #(.N(N), .W(W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .map_en    (map_en),
  .map_src   (map_src),
  .circ_vld  (circ_vld),
  .circ_data (circ_data),
  .pkt_sent  (pkt_sent),
  .pkt_cancel(pkt_cancel),
  .link_vld  (link_vld),
  .link_circ (link_circ),
  .link_data (link_data)
);

// File: tb/hcs_out_arb_tb.sv
module hcs_out_arb_tb_top;
  localparam int N  = 5;
  localparam int W  = 32;
  localparam int IW = $clog2(N);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           map_en = 1'b0;
  logic [IW-1:0]  map_src = '0;
  logic [N-1:0]   circ_vld = '0;
  logic [N*W-1:0] circ_data = '0;
  logic [N-1:0]   pkt_req = '0;
  logic [N*W-1:0] pkt_data = '0;
  logic [N-1:0]   pkt_sent;
  logic           pkt_cancel;
  logic           link_vld;
  logic           link_circ;
  logic [W-1:0]   link_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference state, derived from the requirements.
  bit           m_gv;
  int           m_gi;
  int           m_ptr;
  bit           e_vld;
  bit           e_circ;
  logic [W-1:0] e_data;

  always #10 clk = ~clk;

  hcs_out_arb #(.N(N), .W(W)) dut_i (
    .clk(clk), .rst(rst), .map_en(map_en), .map_src(map_src),
    .circ_vld(circ_vld), .circ_data(circ_data), .pkt_req(pkt_req),
    .pkt_data(pkt_data), .pkt_sent(pkt_sent), .pkt_cancel(pkt_cancel),
    .link_vld(link_vld), .link_circ(link_circ), .link_data(link_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pick_rr(input logic [N-1:0] rq, input int ptr);
    for (int k = 0; k < N; k++) begin
      int c = (ptr + k) % N;
      if (rq[c]) return c;
    end
    return -1;
  endfunction

  task automatic drive(input int circ_pct, input int req_pct, input bit en);
    map_en  = en;
    map_src = IW'($urandom_range(N - 1));
    for (int i = 0; i < N; i++) begin
      circ_vld[i] = ($urandom_range(99) < circ_pct);
      pkt_req[i]  = ($urandom_range(99) < req_pct);
      circ_data[i*W +: W] = $urandom;
      pkt_data[i*W +: W]  = $urandom;
    end
  endtask

  task automatic step(input int circ_pct, input int req_pct, input bit en);
    bit           hit;
    logic [N-1:0] e_sent;
    logic [N-1:0] areq;
    int           w;
    @(negedge clk);
    // Link registers from the previous cycle.
    check(link_vld == e_vld, e_circ ? "R2 link_vld" : (e_vld ? "R4 link_vld" : "R8/R3 link_vld"),
          32'(link_vld), 32'(e_vld));
    check(link_circ == e_circ, e_circ ? "R2 link_circ" : "R4/R8 link_circ",
          32'(link_circ), 32'(e_circ));
    check(link_data == e_data, e_circ ? "R2 link_data" : (e_vld ? "R4 link_data" : "R8 link_data"),
          link_data, e_data);
    drive(circ_pct, req_pct, en);
    #1;
    hit = en && circ_vld[map_src];
    e_sent = '0;
    if (m_gv && !hit) e_sent[m_gi] = 1'b1;
    check(pkt_sent == e_sent, hit ? "R5 pkt_sent" : "R4/R6/R9 pkt_sent",
          32'(pkt_sent), 32'(e_sent));
    check(pkt_cancel == (m_gv && hit), "R5 pkt_cancel", 32'(pkt_cancel), 32'(m_gv && hit));
    // Next link contents.
    if (hit) begin
      e_vld = 1; e_circ = 1; e_data = circ_data[int'(map_src)*W +: W];
    end else if (m_gv) begin
      e_vld = 1; e_circ = 0; e_data = pkt_data[m_gi*W +: W];
    end else begin
      e_vld = 0; e_circ = 0; e_data = '0;
    end
    // Allocation with the sending input removed (R7).
    areq = pkt_req & ~e_sent;
    w = pick_rr(areq, m_ptr);
    m_gv = (w >= 0);
    if (m_gv) begin
      m_gi = w;
      m_ptr = (w + 1) % N;
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    m_gv = 0; m_gi = 0; m_ptr = 0;
    e_vld = 0; e_circ = 0; e_data = '0;
    repeat (3) @(negedge clk);
    check(link_vld == 0 && link_circ == 0, "R1 link idle in reset", 32'(link_vld), 0);
    rst = 1'b0;
    @(negedge clk);
    check(link_vld == 0, "R1 link_vld after reset", 32'(link_vld), 0);
    check(pkt_sent == '0 && pkt_cancel == 0, "R1 no grant after reset", 32'(pkt_sent), 0);
    // Directed: all inputs request, no circuits - rotation (R6, R7).
    repeat (12) step(0, 100, 1'b1);
    // Directed: mapping disabled while circuits are busy (R3).
    repeat (40) step(80, 50, 1'b0);
    // Dense circuits against constant requests (R5).
    repeat (200) step(90, 100, 1'b1);
    // Mixed random loads.
    repeat (1500) step(40, 40, 1'b1);
    repeat (1000) step(15, 70, 1'b1);
    repeat (500) step(50, 20, ($urandom_range(1) == 1));
    step(0, 0, 1'b1);
    step(0, 0, 1'b1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule